// File: doc/BRIEF.md
# Adjacent Pair Fusion Decoder

This block sits in the decode stage of an out-of-order core. Each cycle it receives a group of consecutive 32-bit RISC-V instruction words, one per slot. Each slot has a valid bit and a flag that says the word was expanded from a 2-byte compressed form. The block looks at every neighbouring pair of slots and recognises a fixed set of shift, mask and add idioms. A recognised pair becomes one internal micro-operation. The earlier slot is marked fused and carries a fused-operation code together with the merged operands. The later slot is dropped from the group.

Each fused slot also carries a 2-bit offset tag, so the front end can still retire the dropped instruction and keep its program-counter accounting correct. Pairs are taken from slot 0 upward. An instruction that has already been used as the tail of a pair cannot start another pair. Fusion never reaches across the end of the group.

All outputs are registered, with one cycle of latency. A flush input removes everything that would have been produced in that cycle.

Top module: `fuse_pair_decoder`

## Requirements
- R1: Outputs appear one clock after the inputs are sampled. Every valid slot that is neither fused nor consumed reports `out_valid`=1 and `out_fused`=0. It returns its instruction word unchanged and reports its own fields: src1 from bits 19:15, src2 from bits 24:20, dst from bits 11:7. An invalid input slot gives `out_valid`=0.
- R2: While reset is held, `out_valid` and `out_fused` are all zero, and every `out_fop` and `out_ofs` field is zero.
- R3: When `flush` is high at a sampling edge, every `out_valid` and `out_fused` bit is zero in the following cycle. The next group after the flush is processed normally.
- R4: `slli rd,rs,32` followed by `srli rd,rd,31` gives code 1. The same pair with a right shift of 30 gives code 2.
- R5: `srli rd,rs,8` followed by `andi rd,rd,255` gives code 3.
- R6: `slli rd,rs,K` with K equal to 1, 2, 3 or 4, followed by `add rd,rd,rs2`, gives codes 4, 5, 6 and 7 in that order. Any other shift amount does not fuse.
- R7: `srli rd,rs,K` with K equal to 30, 31 or 32, followed by `add rd,rd,rs2`, gives codes 8, 9 and 10 in that order.
- R8: `andi rd,rs,1` followed by `add` gives code 11, and followed by `addw` gives code 12. `andi rd,rs,-256` followed by `or` gives code 13. Any other partner does not fuse.
- R9: Fusion needs all of these: the first rd is not x0, the second instruction's rd equals the first rd, and its rs1 equals the first rd. When the second instruction reads two registers, its rs2 must also differ from the first rd. If any condition fails, the pair is not fused.
- R10: On a fused pair, the first slot has `out_fused`=1 and a nonzero code. Its src1 is the first instruction's rs1 and its dst is the first rd. Its src2 is the second instruction's rs2 when that instruction reads two registers, and 0 otherwise. The second slot has `out_valid`=0.
- R11: Pairs are resolved from slot 0 upward. A slot consumed as the tail of a pair is never the head of another pair, even if it would match with the slot after it.
- R12: The last slot is never fused. A pair that includes an invalid slot is never fused.
- R13: `out_ofs` on a fused slot is {head was compressed, tail was compressed}, taken from `in_rvc`. On any slot that is not fused, `out_ofs` and `out_fop` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Discard the group sampled at this edge |
| in_valid | input | SLOTS | Per-slot valid |
| in_rvc | input | SLOTS | Per-slot flag: word was expanded from a 2-byte form |
| in_inst | input | SLOTS x ILEN | Per-slot instruction word |
| out_valid | output | SLOTS | Slot carries an instruction |
| out_fused | output | SLOTS | Slot is the head of a fused pair |
| out_fop | output | SLOTS x 4 | Fused-operation code, 0 when not fused |
| out_ofs | output | SLOTS x 2 | Offset tag of a fused pair |
| out_src1 | output | SLOTS x 5 | First source register |
| out_src2 | output | SLOTS x 5 | Second source register |
| out_dst | output | SLOTS x 5 | Destination register |
| out_inst | output | SLOTS x ILEN | Instruction word, delayed one cycle |

## Verification
Two things can happen in the same cycle: a flush, and a group that contains fusible pairs. The bench drives a fusible group with `flush` high. It expects every valid and fused bit to be low, and the code and offset fields to be zero. It then sends a fusible group on the very next edge and expects normal fusion, which shows that no state from the flushed group leaks forward. A second overlap is checked the same way: one slot completes one pair and would also start another. This is driven with slot 0 valid and then invalid, and only the lowest pair is expected to win.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam int REG_W = 5;
  localparam int FOP_W = 4;
  localparam int OFS_W = 2;

  typedef enum logic [FOP_W-1:0] {
    FOP_NONE       = 4'd0,
    FOP_ZXW_SHL1   = 4'd1,
    FOP_ZXW_SHL2   = 4'd2,
    FOP_BYTE1_EXT  = 4'd3,
    FOP_SHL1_ADD   = 4'd4,
    FOP_SHL2_ADD   = 4'd5,
    FOP_SHL3_ADD   = 4'd6,
    FOP_SHL4_ADD   = 4'd7,
    FOP_SHR30_ADD  = 4'd8,
    FOP_SHR31_ADD  = 4'd9,
    FOP_SHR32_ADD  = 4'd10,
    FOP_LSB_ADD    = 4'd11,
    FOP_LSB_ADDW   = 4'd12,
    FOP_HIMASK_OR  = 4'd13
  } fop_e;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_SLLI  = 3'd1,
    K_SRLI  = 3'd2,
    K_ANDI  = 3'd3,
    K_ADD   = 3'd4,
    K_ADDW  = 3'd5,
    K_OR    = 3'd6
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [11:0]      imm;
  } dec_t;

endpackage

// File: rtl/fuse_slot_dec.sv
module fuse_slot_dec
  import fuse_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] inst,
  output dec_t            d
);

  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_REGW = 7'b0111011;

  logic [2:0] f3;
  logic [6:0] f7;

  assign f3 = inst[14:12];
  assign f7 = inst[31:25];

  always_comb begin
    d.kind = K_OTHER;
    d.rd   = inst[11:7];
    d.rs1  = inst[19:15];
    d.rs2  = inst[24:20];
    d.imm  = inst[31:20];
    case (inst[6:0])
      OPC_IMM: begin
        case (f3)
          3'b001:  if (inst[31:26] == 6'd0) d.kind = K_SLLI;
          3'b101:  if (inst[31:26] == 6'd0) d.kind = K_SRLI;
          3'b111:  d.kind = K_ANDI;
          default: d.kind = K_OTHER;
        endcase
      end
      OPC_REG: begin
        if (f7 == 7'd0) begin
          if (f3 == 3'b000)      d.kind = K_ADD;
          else if (f3 == 3'b110) d.kind = K_OR;
        end
      end
      OPC_REGW: begin
        if (f7 == 7'd0 && f3 == 3'b000) d.kind = K_ADDW;
      end
      default: d.kind = K_OTHER;
    endcase
  end

endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
  import fuse_pkg::*;
(
  input  kind_e            a_kind,
  input  logic [REG_W-1:0] a_rd,
  input  logic [REG_W-1:0] a_rs1,
  input  logic [11:0]      a_imm,
  input  dec_t             b,
  output logic             hit,
  output fop_e             fop,
  output logic [REG_W-1:0] src1,
  output logic [REG_W-1:0] src2,
  output logic [REG_W-1:0] dst
);

  localparam logic [11:0] IMM_LSB    = 12'd1;
  localparam logic [11:0] IMM_BYTE   = 12'd255;
  localparam logic [11:0] IMM_HIMASK = 12'hF00;

  logic       two_src;
  logic       regs_ok;
  logic [5:0] a_sh;
  logic [5:0] b_sh;

  assign a_sh    = a_imm[5:0];
  assign b_sh    = b.imm[5:0];
  assign two_src = (b.kind == K_ADD) || (b.kind == K_ADDW) || (b.kind == K_OR);
  assign regs_ok = (a_rd != '0) && (b.rd == a_rd) && (b.rs1 == a_rd) &&
                   !(two_src && (b.rs2 == a_rd));

  always_comb begin
    fop = FOP_NONE;
    case (a_kind)
      K_SLLI: begin
        if (b.kind == K_SRLI && a_sh == 6'd32) begin
          if (b_sh == 6'd31)      fop = FOP_ZXW_SHL1;
          else if (b_sh == 6'd30) fop = FOP_ZXW_SHL2;
        end else if (b.kind == K_ADD) begin
          case (a_sh)
            6'd1:    fop = FOP_SHL1_ADD;
            6'd2:    fop = FOP_SHL2_ADD;
            6'd3:    fop = FOP_SHL3_ADD;
            6'd4:    fop = FOP_SHL4_ADD;
            default: fop = FOP_NONE;
          endcase
        end
      end
      K_SRLI: begin
        if (b.kind == K_ANDI && a_sh == 6'd8 && b.imm == IMM_BYTE) begin
          fop = FOP_BYTE1_EXT;
        end else if (b.kind == K_ADD) begin
          case (a_sh)
            6'd30:   fop = FOP_SHR30_ADD;
            6'd31:   fop = FOP_SHR31_ADD;
            6'd32:   fop = FOP_SHR32_ADD;
            default: fop = FOP_NONE;
          endcase
        end
      end
      K_ANDI: begin
        if (a_imm == IMM_LSB) begin
          if (b.kind == K_ADD)       fop = FOP_LSB_ADD;
          else if (b.kind == K_ADDW) fop = FOP_LSB_ADDW;
        end else if (a_imm == IMM_HIMASK && b.kind == K_OR) begin
          fop = FOP_HIMASK_OR;
        end
      end
      default: fop = FOP_NONE;
    endcase
  end

  assign hit  = regs_ok && (fop != FOP_NONE);
  assign src1 = a_rs1;
  assign src2 = two_src ? b.rs2 : '0;
  assign dst  = a_rd;

endmodule

// File: rtl/fuse_resolve.sv
module fuse_resolve #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0] valid,
  input  logic [SLOTS-1:0] hit,
  output logic [SLOTS-1:0] lead,
  output logic [SLOTS-1:0] keep
);

  logic [SLOTS:0] valid_x;
  assign valid_x = {1'b0, valid};

  always_comb begin
    logic consumed;
    consumed = 1'b0;
    lead     = '0;
    keep     = '0;
    for (int i = 0; i < SLOTS; i++) begin
      keep[i]  = valid_x[i] && !consumed;
      lead[i]  = keep[i] && valid_x[i+1] && hit[i];
      consumed = lead[i];
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS-1; i++) begin
      p_no_chain_r11: assert (!(lead[i] && lead[i+1]));
    end
  end

endmodule

// File: rtl/fuse_pair_decoder.sv
module fuse_pair_decoder
  import fuse_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int ILEN  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [SLOTS-1:0]             in_valid,
  input  logic [SLOTS-1:0]             in_rvc,
  input  logic [SLOTS-1:0][ILEN-1:0]   in_inst,
  output logic [SLOTS-1:0]             out_valid,
  output logic [SLOTS-1:0]             out_fused,
  output logic [SLOTS-1:0][FOP_W-1:0]  out_fop,
  output logic [SLOTS-1:0][OFS_W-1:0]  out_ofs,
  output logic [SLOTS-1:0][REG_W-1:0]  out_src1,
  output logic [SLOTS-1:0][REG_W-1:0]  out_src2,
  output logic [SLOTS-1:0][REG_W-1:0]  out_dst,
  output logic [SLOTS-1:0][ILEN-1:0]   out_inst
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  dec_t             dec      [SLOTS];
  logic [SLOTS-1:0] pair_hit;
  fop_e             pair_fop [SLOTS];
  logic [REG_W-1:0] pair_s1  [SLOTS];
  logic [REG_W-1:0] pair_s2  [SLOTS];
  logic [REG_W-1:0] pair_dst [SLOTS];
  logic [SLOTS-1:0] lead;
  logic [SLOTS-1:0] keep;
  logic [SLOTS:0]   rvc_x;

  assign rvc_x = {1'b0, in_rvc};

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    fuse_slot_dec #(.ILEN(ILEN)) u_dec (
      .inst (in_inst[g]),
      .d    (dec[g])
    );
    if (g < SLOTS-1) begin : g_pair
      fuse_pair_match u_pm (
        .a_kind (dec[g].kind),
        .a_rd   (dec[g].rd),
        .a_rs1  (dec[g].rs1),
        .a_imm  (dec[g].imm),
        .b      (dec[g+1]),
        .hit    (pair_hit[g]),
        .fop    (pair_fop[g]),
        .src1   (pair_s1[g]),
        .src2   (pair_s2[g]),
        .dst    (pair_dst[g])
      );
    end else begin : g_tail
      assign pair_hit[g] = 1'b0;
      assign pair_fop[g] = FOP_NONE;
      assign pair_s1[g]  = '0;
      assign pair_s2[g]  = '0;
      assign pair_dst[g] = '0;
    end
  end

  fuse_resolve #(.SLOTS(SLOTS)) u_res (
    .valid (in_valid),
    .hit   (pair_hit),
    .lead  (lead),
    .keep  (keep)
  );

  // next-state
  logic [SLOTS-1:0]            nx_valid;
  logic [SLOTS-1:0]            nx_fused;
  logic [SLOTS-1:0][FOP_W-1:0] nx_fop;
  logic [SLOTS-1:0][OFS_W-1:0] nx_ofs;
  logic [SLOTS-1:0][REG_W-1:0] nx_s1;
  logic [SLOTS-1:0][REG_W-1:0] nx_s2;
  logic [SLOTS-1:0][REG_W-1:0] nx_dst;
  logic                        load_data;

  assign load_data = |in_valid;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      nx_valid[i] = !flush && keep[i];
      nx_fused[i] = !flush && lead[i];
      nx_fop[i]   = nx_fused[i] ? pair_fop[i] : FOP_NONE;
      nx_ofs[i]   = nx_fused[i] ? {rvc_x[i], rvc_x[i+1]} : '0;
      nx_s1[i]    = lead[i] ? pair_s1[i]  : dec[i].rs1;
      nx_s2[i]    = lead[i] ? pair_s2[i]  : dec[i].rs2;
      nx_dst[i]   = lead[i] ? pair_dst[i] : dec[i].rd;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= '0;
      out_fused <= '0;
      out_fop   <= '0;
      out_ofs   <= '0;
    end else begin
      out_valid <= nx_valid;
      out_fused <= nx_fused;
      out_fop   <= nx_fop;
      out_ofs   <= nx_ofs;
    end
  end

  always_ff @(posedge clk) begin
    if (load_data) begin
      out_src1 <= nx_s1;
      out_src2 <= nx_s2;
      out_dst  <= nx_dst;
      out_inst <= in_inst;
    end
  end

  // assertions
  p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_q)
    flush |=> (out_valid == '0 && out_fused == '0));

  for (genvar a = 0; a < SLOTS; a++) begin : g_chk
    p_fused_live_r10: assert property (@(posedge clk) disable iff (!rst_q)
      out_fused[a] |-> (out_valid[a] && out_fop[a] != '0));
    p_idle_fields_r13: assert property (@(posedge clk) disable iff (!rst_q)
      !out_fused[a] |-> (out_ofs[a] == '0 && out_fop[a] == '0));
    if (a < SLOTS-1) begin : g_drop
      p_tail_dropped_r10: assert property (@(posedge clk) disable iff (!rst_q)
        out_fused[a] |-> !out_valid[a+1]);
    end
  end

endmodule

// File: tb/fuse_pair_decoder_tb.sv
module fuse_pair_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int S          = 4;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic                  clk;
  logic                  rst_n;
  logic                  flush;
  logic [S-1:0]          in_valid;
  logic [S-1:0]          in_rvc;
  logic [S-1:0][31:0]    in_inst;
  logic [S-1:0]          out_valid;
  logic [S-1:0]          out_fused;
  logic [S-1:0][3:0]     out_fop;
  logic [S-1:0][1:0]     out_ofs;
  logic [S-1:0][4:0]     out_src1;
  logic [S-1:0][4:0]     out_src2;
  logic [S-1:0][4:0]     out_dst;
  logic [S-1:0][31:0]    out_inst;

  fuse_pair_decoder #(.SLOTS(S), .ILEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_rvc(in_rvc), .in_inst(in_inst),
    .out_valid(out_valid), .out_fused(out_fused), .out_fop(out_fop),
    .out_ofs(out_ofs), .out_src1(out_src1), .out_src2(out_src2),
    .out_dst(out_dst), .out_inst(out_inst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [S-1:0]       v;
    logic [S-1:0]       f;
    logic [S-1:0][3:0]  fop;
    logic [S-1:0][1:0]  ofs;
    logic [S-1:0][4:0]  s1;
    logic [S-1:0][4:0]  s2;
    logic [S-1:0][4:0]  d;
    logic [S-1:0][31:0] inst;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  ex;
  logic [S-1:0]       st_valid;
  logic [S-1:0]       st_rvc;
  logic [S-1:0][31:0] st_inst;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [31:0] f_slli(logic [4:0] rd, logic [4:0] rs, logic [5:0] sh);
    return {6'b0, sh, rs, 3'b001, rd, 7'h13};
  endfunction
  function automatic logic [31:0] f_srli(logic [4:0] rd, logic [4:0] rs, logic [5:0] sh);
    return {6'b0, sh, rs, 3'b101, rd, 7'h13};
  endfunction
  function automatic logic [31:0] f_andi(logic [4:0] rd, logic [4:0] rs, logic [11:0] imm);
    return {imm, rs, 3'b111, rd, 7'h13};
  endfunction
  function automatic logic [31:0] f_add(logic [4:0] rd, logic [4:0] a, logic [4:0] b);
    return {7'b0, b, a, 3'b000, rd, 7'h33};
  endfunction
  function automatic logic [31:0] f_or(logic [4:0] rd, logic [4:0] a, logic [4:0] b);
    return {7'b0, b, a, 3'b110, rd, 7'h33};
  endfunction
  function automatic logic [31:0] f_addw(logic [4:0] rd, logic [4:0] a, logic [4:0] b);
    return {7'b0, b, a, 3'b000, rd, 7'h3B};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic stage_clear();
    st_valid = '0; st_rvc = '0;
    for (int s = 0; s < S; s++) st_inst[s] = NOP;
    ex = '0;
  endtask

  task automatic put(int s, logic [31:0] ins, logic v = 1'b1, logic rvc = 1'b0);
    st_inst[s] = ins; st_valid[s] = v; st_rvc[s] = rvc;
    ex.v[s] = v; ex.inst[s] = ins;
    ex.s1[s] = ins[19:15]; ex.s2[s] = ins[24:20]; ex.d[s] = ins[11:7];
  endtask

  task automatic mark(int s, logic [3:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] d);
    ex.f[s] = 1'b1; ex.fop[s] = op;
    ex.s1[s] = a; ex.s2[s] = b; ex.d[s] = d;
    ex.ofs[s] = {st_rvc[s], st_rvc[s+1]};
    ex.v[s+1] = 1'b0;
  endtask

  task automatic go(string tag, logic fl = 1'b0);
    @(negedge clk);
    if (fl) begin ex.v = '0; ex.f = '0; ex.fop = '0; ex.ofs = '0; end
    flush = fl; in_valid = st_valid; in_rvc = st_rvc; in_inst = st_inst;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    flush = 1'b0; in_valid = '0; in_rvc = '0;
  endtask

  // monitor
  exp_t  m_e;
  string m_t;
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      m_e = exp_q.pop_front();
      m_t = tag_q.pop_front();
      chk(out_valid == m_e.v, m_t, "valid", 64'(out_valid), 64'(m_e.v));
      chk(out_fused == m_e.f, m_t, "fused", 64'(out_fused), 64'(m_e.f));
      chk(out_fop == m_e.fop, m_t, "fop", 64'(out_fop), 64'(m_e.fop));
      chk(out_ofs == m_e.ofs, m_t, "ofs", 64'(out_ofs), 64'(m_e.ofs));
      for (int s = 0; s < S; s++) begin
        if (m_e.v[s]) begin
          chk({out_src1[s], out_src2[s], out_dst[s]} == {m_e.s1[s], m_e.s2[s], m_e.d[s]},
              m_t, $sformatf("slot%0d regs", s),
              64'({out_src1[s], out_src2[s], out_dst[s]}), 64'({m_e.s1[s], m_e.s2[s], m_e.d[s]}));
          chk(out_inst[s] == m_e.inst[s], m_t, $sformatf("slot%0d inst", s),
              64'(out_inst[s]), 64'(m_e.inst[s]));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = '0; in_rvc = '0;
    for (int s = 0; s < S; s++) in_inst[s] = NOP;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0 && out_fused == '0, "R2", "valid/fused in reset",
        64'({out_valid, out_fused}), 64'(0));
    chk(out_fop == '0 && out_ofs == '0, "R2", "fop/ofs in reset",
        64'({out_fop, out_ofs}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 plain pass-through, slot 1 invalid
    stage_clear(); put(0, f_add(3, 1, 2)); put(1, NOP, 1'b0); put(2, f_or(9, 10, 11)); put(3, NOP);
    go("R1");
    // R4
    stage_clear(); put(0, f_slli(5, 6, 32)); put(1, f_srli(5, 5, 31));
    put(2, f_slli(7, 8, 32)); put(3, f_srli(7, 7, 30));
    mark(0, 4'd1, 6, 0, 5); mark(2, 4'd2, 8, 0, 7); go("R4");
    // R5
    stage_clear(); put(0, NOP); put(1, f_srli(12, 13, 8)); put(2, f_andi(12, 12, 12'd255)); put(3, NOP);
    mark(1, 4'd3, 13, 0, 12); go("R5");
    // R6
    stage_clear(); put(0, f_slli(5, 6, 1)); put(1, f_add(5, 5, 7));
    put(2, f_slli(8, 9, 2)); put(3, f_add(8, 8, 10));
    mark(0, 4'd4, 6, 7, 5); mark(2, 4'd5, 9, 10, 8); go("R6");
    stage_clear(); put(0, f_slli(5, 6, 3)); put(1, f_add(5, 5, 7));
    put(2, f_slli(8, 9, 4)); put(3, f_add(8, 8, 10));
    mark(0, 4'd6, 6, 7, 5); mark(2, 4'd7, 9, 10, 8); go("R6");
    // R7
    stage_clear(); put(0, f_srli(5, 6, 30)); put(1, f_add(5, 5, 7));
    put(2, f_srli(8, 9, 31)); put(3, f_add(8, 8, 10));
    mark(0, 4'd8, 6, 7, 5); mark(2, 4'd9, 9, 10, 8); go("R7");
    stage_clear(); put(0, NOP); put(1, f_srli(14, 15, 32)); put(2, f_add(14, 14, 16)); put(3, NOP);
    mark(1, 4'd10, 15, 16, 14); go("R7");
    // R8
    stage_clear(); put(0, f_andi(5, 6, 12'd1)); put(1, f_add(5, 5, 7));
    put(2, f_andi(8, 9, 12'd1)); put(3, f_addw(8, 8, 10));
    mark(0, 4'd11, 6, 7, 5); mark(2, 4'd12, 9, 10, 8); go("R8");
    stage_clear(); put(0, f_andi(5, 6, 12'hF00)); put(1, f_or(5, 5, 7));
    put(2, f_andi(8, 9, 12'd1)); put(3, f_or(8, 8, 10));
    mark(0, 4'd13, 6, 7, 5); go("R8 partner");
    // R9 negatives
    stage_clear(); put(0, f_slli(0, 6, 1)); put(1, f_add(0, 0, 7));
    put(2, f_slli(5, 6, 1)); put(3, f_add(4, 5, 7)); go("R9 rd0/dst");
    stage_clear(); put(0, f_slli(5, 6, 1)); put(1, f_add(5, 7, 5));
    put(2, f_slli(5, 6, 1)); put(3, f_add(5, 5, 5)); go("R9 rs1/rs2");
    stage_clear(); put(0, f_srli(5, 6, 8)); put(1, f_andi(5, 5, 12'd254));
    put(2, f_slli(5, 6, 5)); put(3, f_add(5, 5, 7)); go("R6 R9 imm");
    // R11 overlap
    stage_clear(); put(0, f_slli(5, 6, 32)); put(1, f_srli(5, 5, 31)); put(2, f_add(5, 5, 9)); put(3, NOP);
    mark(0, 4'd1, 6, 0, 5); go("R11 low wins");
    stage_clear(); put(0, f_slli(5, 6, 32), 1'b0); put(1, f_srli(5, 5, 31)); put(2, f_add(5, 5, 9)); put(3, NOP);
    mark(1, 4'd9, 5, 9, 5); go("R11 next pair");
    // R12
    stage_clear(); put(0, f_srli(5, 6, 8)); put(1, f_andi(5, 5, 12'd255), 1'b0);
    put(2, NOP); put(3, f_slli(7, 8, 1)); go("R12 gap/last");
    stage_clear(); put(0, f_slli(5, 6, 1)); put(1, f_add(5, 5, 7), 1'b0); go("R12 invalid tail");
    // R13
    stage_clear(); put(0, f_slli(5, 6, 1), 1'b1, 1'b1); put(1, f_add(5, 5, 7), 1'b1, 1'b0);
    put(2, f_slli(8, 9, 2), 1'b1, 1'b0); put(3, f_add(8, 8, 10), 1'b1, 1'b1);
    mark(0, 4'd4, 6, 7, 5); mark(2, 4'd5, 9, 10, 8); go("R13");
    stage_clear(); put(0, NOP, 1'b1, 1'b1); put(1, f_andi(5, 6, 12'd1), 1'b1, 1'b1);
    put(2, f_add(5, 5, 7), 1'b1, 1'b1); put(3, NOP, 1'b1, 1'b1);
    mark(1, 4'd11, 6, 7, 5); go("R13 both");
    // R3 flush with fusible group, then recovery
    stage_clear(); put(0, f_slli(5, 6, 32)); put(1, f_srli(5, 5, 31));
    put(2, f_andi(8, 9, 12'd1), 1'b1, 1'b1); put(3, f_add(8, 8, 10), 1'b1, 1'b1);
    go("R3 flush", 1'b1);
    stage_clear(); put(0, f_slli(5, 6, 32)); put(1, f_srli(5, 5, 31));
    put(2, f_andi(8, 9, 12'd1), 1'b1, 1'b1); put(3, f_add(8, 8, 10), 1'b1, 1'b1);
    mark(0, 4'd1, 6, 0, 5); mark(2, 4'd11, 9, 10, 8); go("R3 recover");
    stage_clear(); go("R1 empty");
    idle();
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule